// File: doc/BRIEF.md
# Instruction Address Sequencer with Two-Level Return Stack

This block produces the program-memory fetch address for a small 8-bit controller whose pipeline fetches one instruction while the one before it executes. It divides the system clock into four phases, T1 to T4. At the end of every T4 it picks the next fetch address from one of these sources: increment, taken skip, a write to the counter's low byte, jump, call, return from a two-entry hardware stack, or a fixed interrupt vector. Whenever the executing instruction redirects the flow, the instruction already fetched is thrown away. The block flags the following instruction cycle as a dummy cycle so the execute stage does nothing in it.

Decoding happens outside the block. It presents its results as one-bit strobes that are held for the whole instruction cycle, together with the 14-bit instruction word, whose low bits carry the jump or call address. The width of the counter is a parameter: 9, 10 or 11 bits, for 512, 1024 or 2048 words.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held and after it is released, fetch_addr is 0 (the reset vector), dummy is 1, t_phase is 4'b0001 (T1) and stack_full is 0.
- R2: t_phase has exactly one bit set. The set bit moves from bit 0 (T1) up to bit 3 (T4) on successive clocks and then returns to bit 0. fetch_addr and dummy change only on the edge that ends T4.
- R3: At a cycle end where no strobe or interrupt takes effect, fetch_addr advances by one, wrapping from all-ones to 0, and dummy becomes 0.
- R4: A taken skip advances fetch_addr by one and sets dummy. The instruction that was already fetched is discarded, so execution moves two words past the skipping instruction.
- R5: A low-byte write replaces fetch_addr[7:0] with pcl_data and keeps the upper bits of the current fetch_addr. dummy becomes 1.
- R6: A jump loads fetch_addr from instr_word[PC_W-1:0] and sets dummy.
- R7: A call loads fetch_addr from instr_word[PC_W-1:0], pushes the current fetch_addr (the address of the next instruction) and sets dummy.
- R8: A return loads fetch_addr from the newest stack entry, pops that entry and sets dummy.
- R9: When several strobes are high at once, exactly one takes effect, in this order: return, call, jump, low-byte write, skip.
- R10: All strobes and interrupt requests are ignored at the end of a dummy cycle. fetch_addr then advances by one and dummy becomes 0.
- R11: An interrupt is accepted only at the end of a non-dummy cycle in which no strobe is high and stack_full is 0. irq_ext loads 004h and irq_tmr loads 008h, with irq_ext taking precedence. The current fetch_addr is pushed and dummy becomes 1. A request that is not accepted has no effect at that cycle end.
- R12: stack_full is 1 exactly when both stack levels hold an address. A push while the stack is full discards the oldest entry, so two returns then yield the two newest addresses, newest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 14 | Executing instruction word; low PC_W bits are the jump or call address |
| pcl_data | input | 8 | Data written to the counter's low byte |
| skip_take | input | 1 | Conditional skip taken |
| pcl_wr | input | 1 | Low-byte write of the counter |
| jmp | input | 1 | Unconditional jump |
| call | input | 1 | Subroutine call |
| ret | input | 1 | Return from subroutine or interrupt |
| irq_ext | input | 1 | External interrupt request |
| irq_tmr | input | 1 | Timer overflow interrupt request |
| fetch_addr | output | PC_W | Address of the instruction being fetched |
| dummy | output | 1 | The current instruction cycle executes nothing |
| t_phase | output | 4 | One-hot phase T1..T4 |
| stack_full | output | 1 | Both stack levels occupied |

## Verification
Directed sequences are checked against a small reference model kept in the bench. The plain increment run, including the wrap from 7FFh to 0, is set against skips, which advance the same way but raise dummy. Two low-byte writes made from different pages show that the upper bits are kept and not cleared. Combined strobes separate the priority order. A call paired with a jump is told apart from a lone jump only by the address a later return brings back. Interrupts are tried at a free cycle end, next to a strobe, and with the stack full, which shows when a request is accepted. A triple call checks which entries survive an overflow.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SRC_INC, SRC_SKIP, SRC_PCL, SRC_JMP, SRC_CALL, SRC_RET, SRC_VEC_EXT, SRC_VEC_TMR
  } nxt_src_e;

  localparam int VEC_RESET = 0;
  localparam int VEC_EXT   = 4;
  localparam int VEC_TMR   = 8;
  localparam int LOW_W     = 8;
endpackage

// File: rtl/pcs_phase_gen.sv
module pcs_phase_gen #(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  output logic [NPH-1:0] ph_onehot,
  output logic           cyc_end
);
  always_ff @(posedge clk) begin
    if (rst) ph_onehot <= {{(NPH-1){1'b0}}, 1'b1};
    else     ph_onehot <= {ph_onehot[NPH-2:0], ph_onehot[NPH-1]};
  end

  assign cyc_end = ph_onehot[NPH-1];

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(ph_onehot) == 1);
  p_phase_walk_r2: assert property (@(posedge clk) disable iff (rst)
    ph_onehot[NPH-1] |=> ph_onehot[0]);
endmodule

// File: rtl/pcs_next_sel.sv
module pcs_next_sel
  import pcs_pkg::*;
(
  input  logic     in_dummy,
  input  logic     skip_take,
  input  logic     pcl_wr,
  input  logic     jmp,
  input  logic     call,
  input  logic     ret,
  input  logic     irq_ext,
  input  logic     irq_tmr,
  input  logic     stk_full,
  output nxt_src_e src
);
  logic any_strobe;
  assign any_strobe = skip_take | pcl_wr | jmp | call | ret;

  always_comb begin
    src = SRC_INC;
    if (!in_dummy) begin
      if (ret)                   src = SRC_RET;
      else if (call)             src = SRC_CALL;
      else if (jmp)              src = SRC_JMP;
      else if (pcl_wr)           src = SRC_PCL;
      else if (skip_take)        src = SRC_SKIP;
      else if (!any_strobe && !stk_full) begin
        if (irq_ext)             src = SRC_VEC_EXT;
        else if (irq_tmr)        src = SRC_VEC_TMR;
      end
    end
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 2,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     ent [DEPTH];
  logic [LVL_W-1:0] lvl;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)       ent[i] <= '0;
        else if (push) ent[i] <= din;
        else if (pop && DEPTH > 1) ent[i] <= ent[(DEPTH > 1) ? 1 : 0];
      end
    end else if (i == DEPTH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)       ent[i] <= '0;
        else if (push) ent[i] <= ent[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)       ent[i] <= '0;
        else if (push) ent[i] <= ent[i-1];
        else if (pop)  ent[i] <= ent[i+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else if (push && lvl != LVL_W'(DEPTH)) lvl <= lvl + 1'b1;
    else if (pop && lvl != '0)             lvl <= lvl - 1'b1;
  end

  assign top  = ent[0];
  assign full = (lvl == LVL_W'(DEPTH));

  p_level_bound_r12: assert property (@(posedge clk) disable iff (rst)
    lvl <= LVL_W'(DEPTH));
  p_push_full_stays_r12: assert property (@(posedge clk) disable iff (rst)
    (full && push) |=> full);
  p_push_lands_r7: assert property (@(posedge clk) disable iff (rst)
    push |=> top == $past(din));
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W    = 11,
  parameter int INSTR_W = 14,
  parameter int STK_D   = 2,
  parameter int NPH     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [7:0]         pcl_data,
  input  logic               skip_take,
  input  logic               pcl_wr,
  input  logic               jmp,
  input  logic               call,
  input  logic               ret,
  input  logic               irq_ext,
  input  logic               irq_tmr,
  output logic [PC_W-1:0]    fetch_addr,
  output logic               dummy,
  output logic [NPH-1:0]     t_phase,
  output logic               stack_full
);
  localparam int HI_W = PC_W - LOW_W;

  logic            cyc_end;
  nxt_src_e        src;
  logic [PC_W-1:0] pc_q, stk_top, tgt;
  logic            dummy_q, push, pop;

  assign tgt = instr_word[PC_W-1:0];

  pcs_phase_gen #(.NPH(NPH)) u_phase (
    .clk(clk), .rst(rst), .ph_onehot(t_phase), .cyc_end(cyc_end));

  pcs_next_sel u_sel (
    .in_dummy(dummy_q), .skip_take(skip_take), .pcl_wr(pcl_wr), .jmp(jmp),
    .call(call), .ret(ret), .irq_ext(irq_ext), .irq_tmr(irq_tmr),
    .stk_full(stack_full), .src(src));

  assign push = cyc_end && (src == SRC_CALL || src == SRC_VEC_EXT || src == SRC_VEC_TMR);
  assign pop  = cyc_end && (src == SRC_RET);

  pcs_stack #(.DEPTH(STK_D), .W(PC_W)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(pc_q),
    .top(stk_top), .full(stack_full));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= PC_W'(VEC_RESET);
      dummy_q <= 1'b1;
    end else if (cyc_end) begin
      dummy_q <= (src != SRC_INC);
      case (src)
        SRC_INC, SRC_SKIP: pc_q <= pc_q + 1'b1;
        SRC_PCL:           pc_q <= {pc_q[PC_W-1 -: HI_W], pcl_data};
        SRC_JMP, SRC_CALL: pc_q <= tgt;
        SRC_RET:           pc_q <= stk_top;
        SRC_VEC_EXT:       pc_q <= PC_W'(VEC_EXT);
        default:           pc_q <= PC_W'(VEC_TMR);
      endcase
    end
  end

  assign fetch_addr = pc_q;
  assign dummy      = dummy_q;

  p_hold_midcycle_r2: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> ($stable(pc_q) && $stable(dummy_q)));
  p_dummy_ignores_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && dummy_q) |=> (!dummy_q && pc_q == PC_W'($past(pc_q) + 1'b1)));
  p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !dummy_q && jmp && !ret && !call)
      |=> (dummy_q && pc_q == $past(instr_word[PC_W-1:0])));
  p_irq_blocked_full_r11: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !dummy_q && stack_full && !skip_take && !pcl_wr && !jmp && !call && !ret)
      |=> !dummy_q);
  p_ret_marks_dummy_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_end && !dummy_q && ret) |=> dummy_q);
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam int PC_W = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [13:0]     instr_word = '0;
  logic [7:0]      pcl_data = '0;
  logic            skip_take = 0, pcl_wr = 0, jmp = 0, call = 0, ret = 0;
  logic            irq_ext = 0, irq_tmr = 0;
  logic [PC_W-1:0] fetch_addr;
  logic            dummy, stack_full;
  logic [3:0]      t_phase;

  int n_chk = 0;
  int n_err = 0;

  logic [PC_W-1:0] m_pc;
  logic            m_dummy;
  logic [PC_W-1:0] m_stk [2];
  int              m_lvl;

  always #2 clk = ~clk;

  pc_sequencer #(.PC_W(PC_W)) u_pc_sequencer (
    .clk(clk), .rst(rst), .instr_word(instr_word), .pcl_data(pcl_data),
    .skip_take(skip_take), .pcl_wr(pcl_wr), .jmp(jmp), .call(call), .ret(ret),
    .irq_ext(irq_ext), .irq_tmr(irq_tmr), .fetch_addr(fetch_addr),
    .dummy(dummy), .t_phase(t_phase), .stack_full(stack_full));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_push(input logic [PC_W-1:0] v);
    m_stk[1] = m_stk[0];
    m_stk[0] = v;
    if (m_lvl < 2) m_lvl++;
  endtask

  // one instruction cycle; inputs applied in T1, checked after the T4 edge
  task automatic step(input string tag, input logic s_skip, input logic s_pclw,
                      input logic [7:0] d, input logic s_jmp, input logic s_call,
                      input logic s_ret, input logic s_ie, input logic s_it,
                      input logic [13:0] w);
    logic [PC_W-1:0] nx;
    logic            nd;
    skip_take = s_skip; pcl_wr = s_pclw; pcl_data = d; jmp = s_jmp; call = s_call;
    ret = s_ret; irq_ext = s_ie; irq_tmr = s_it; instr_word = w;
    nx = m_pc + 1'b1;
    nd = 1'b1;
    if (m_dummy) nd = 1'b0;
    else if (s_ret) begin
      nx = m_stk[0]; m_stk[0] = m_stk[1];
      if (m_lvl > 0) m_lvl--;
    end
    else if (s_call) begin m_push(m_pc); nx = w[PC_W-1:0]; end
    else if (s_jmp)  nx = w[PC_W-1:0];
    else if (s_pclw) nx = {m_pc[PC_W-1:8], d};
    else if (s_skip) nx = m_pc + 1'b1;
    else if ((s_ie || s_it) && m_lvl < 2) begin
      m_push(m_pc); nx = s_ie ? PC_W'(4) : PC_W'(8);
    end
    else nd = 1'b0;
    m_pc = nx; m_dummy = nd;
    repeat (4) @(posedge clk);
    @(negedge clk);
    {skip_take, pcl_wr, jmp, call, ret, irq_ext, irq_tmr} = '0;
    check({tag, " addr"}, int'(fetch_addr), int'(m_pc));
    check({tag, " dummy"}, int'(dummy), int'(m_dummy));
    check({tag, " full"}, int'(stack_full), int'(m_lvl == 2));
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 8'h00, 0, 0, 0, 0, 0, 14'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr", int'(fetch_addr), 0);
    check("R1 dummy", int'(dummy), 1);
    check("R1 phase", int'(t_phase), 1);
    check("R1 full", int'(stack_full), 0);
    rst = 1'b0;
    m_pc = '0; m_dummy = 1'b1; m_stk[0] = '0; m_stk[1] = '0; m_lvl = 0;
  endtask

  task automatic t_phase_walk();
    logic [PC_W-1:0] a0;
    a0 = fetch_addr;
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      check("R2 phase", int'(t_phase), 1 << k);
      check("R2 addr held", int'(fetch_addr), int'(a0));
    end
    @(posedge clk); @(negedge clk);
    check("R2 phase wrap", int'(t_phase), 1);
    m_pc = m_pc + 1'b1; m_dummy = 1'b0;
    check("R2 addr at T1", int'(fetch_addr), int'(m_pc));
  endtask

  task automatic t_dummy_ignore();
    idle("R3 inc");
    step("R4 skip", 1, 0, 8'h00, 0, 0, 0, 0, 0, 14'h0);
    step("R10 jmp in dummy", 0, 0, 8'h00, 1, 0, 0, 1, 0, 14'h155);
    idle("R3 inc2");
  endtask

  task automatic t_pcl_jump();
    step("R5 pcl page0", 0, 1, 8'h80, 0, 0, 0, 0, 0, 14'h0);
    idle("R5 after");
    step("R6 jmp", 0, 0, 8'h00, 1, 0, 0, 0, 0, 14'h3F0);
    idle("R6 after");
    step("R5 pcl page3", 0, 1, 8'h10, 0, 0, 0, 0, 0, 14'h0);
    idle("R5 after2");
  endtask

  task automatic t_call_ret();
    step("R7 call", 0, 0, 8'h00, 0, 1, 0, 0, 0, 14'h200);
    idle("R7 body");
    step("R8 ret", 0, 0, 8'h00, 0, 0, 1, 0, 0, 14'h0);
    idle("R8 after");
  endtask

  task automatic t_priority();
    step("R9 jmp>pcl>skip", 1, 1, 8'h44, 1, 0, 0, 0, 0, 14'h123);
    idle("R9 a");
    step("R9 call>jmp", 0, 0, 8'h00, 1, 1, 0, 0, 0, 14'h050);
    idle("R9 b");
    step("R9 ret>jmp", 0, 0, 8'h00, 1, 0, 1, 0, 0, 14'h700);
    idle("R9 c");
    step("R9 pcl>skip", 1, 1, 8'hC3, 0, 0, 0, 0, 0, 14'h0);
    idle("R9 d");
  endtask

  task automatic t_irq();
    step("R11 ext>tmr", 0, 0, 8'h00, 0, 0, 0, 1, 1, 14'h0);
    idle("R11 isr");
    step("R11 ret", 0, 0, 8'h00, 0, 0, 1, 0, 0, 14'h0);
    idle("R11 back");
    step("R11 tmr", 0, 0, 8'h00, 0, 0, 0, 0, 1, 14'h0);
    idle("R11 isr2");
    step("R11 ret2", 0, 0, 8'h00, 0, 0, 1, 0, 0, 14'h0);
    idle("R11 back2");
    step("R11 strobe wins", 0, 0, 8'h00, 1, 0, 0, 1, 0, 14'h2A0);
    idle("R11 after");
  endtask

  task automatic t_overflow();
    step("R12 call1", 0, 0, 8'h00, 0, 1, 0, 0, 0, 14'h100);
    idle("R12 s1");
    step("R12 call2", 0, 0, 8'h00, 0, 1, 0, 0, 0, 14'h180);
    idle("R12 s2");
    step("R11 irq when full", 0, 0, 8'h00, 0, 0, 0, 1, 0, 14'h0);
    step("R12 call3", 0, 0, 8'h00, 0, 1, 0, 0, 0, 14'h600);
    idle("R12 s3");
    step("R12 ret newest", 0, 0, 8'h00, 0, 0, 1, 0, 0, 14'h0);
    idle("R12 r1");
    step("R12 ret second", 0, 0, 8'h00, 0, 0, 1, 0, 0, 14'h0);
    idle("R12 r2");
  endtask

  task automatic t_wrap();
    step("R6 jmp top", 0, 0, 8'h00, 1, 0, 0, 0, 0, 14'h7FF);
    idle("R3 wrap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1-timeout actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_phase_walk();
    t_dummy_ignore();
    t_pcl_jump();
    t_call_ret();
    t_priority();
    t_irq();
    t_overflow();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule